// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block gathers five interrupt requests: two active-low external pins, two timer overflow requests and one serial-port request. It decides which one the processor sequencer should take next. A global enable and one enable per source gate the requests. Each source is assigned to either the low or the high priority level. Within a level a fixed chain breaks ties. The winner is shown on a request line together with its vector address. The sequencer answers with a one-cycle acknowledge when it begins the hardware call. It later sends a one-cycle return strobe when the handler finishes.

Two in-service flags, one per level, record which handlers are running. A high-priority request may interrupt a low-priority handler. No other nesting is allowed. The external pins are sampled once per machine cycle of `CYCLE_CLKS` clocks, which is 12 by default. Each pin is set up either for low-level triggering or for falling-edge triggering. An edge-triggered pin latches a pending flag. That flag clears itself when the pin's vector is acknowledged.

Top module: `intc2l`

## Requirements
- R1: After reset, `irq` is 0, `in_svc` is 2'b00 and `vec` is 8'h00. `vec` reads 8'h00 whenever `irq` is 0.
- R2: The vector for each source is fixed: external 0 gives 8'h03, timer 0 gives 8'h0B, external 1 gives 8'h13, timer 1 gives 8'h1B and serial gives 8'h23. An enabled request with no in-service level raises `irq` in the same cycle.
- R3: When `glb_en` is 0, or when a source's bit in `src_en` is 0, that source never raises `irq`. Source bit order in `src_en` and `src_hi` is: bit0 external 0, bit1 timer 0, bit2 external 1, bit3 timer 1, bit4 serial.
- R4: When several requests are pending at the same level, the one with the lowest bit index wins.
- R5: Any pending high-level request, marked by a 1 in its `src_hi` bit, wins over every low-level request. `irq_hi` is 1 exactly when the presented request is high-level.
- R6: While `in_svc[0]` (low in service) is 1, only high-level requests raise `irq`. While `in_svc[1]` (high in service) is 1, `irq` stays 0.
- R7: An `ack` while `irq` is 1 sets `in_svc[1]` for a high-level winner or `in_svc[0]` for a low-level winner at the next clock edge. An `ack` while `irq` is 0 changes nothing.
- R8: A `reti` pulse clears `in_svc[1]` if it is set. Otherwise it clears `in_svc[0]`.
- R9: With `ext_edge[i]` equal to 0, external request i is active while the last sample of `ext_n[i]` is 0. It drops once a sample reads 1.
- R10: With `ext_edge[i]` equal to 1, a sample of 0 that follows a sample of 1 latches a pending request. The request stays pending after the pin returns high. It is cleared when that source's vector is acknowledged.
- R11: The pins are sampled on every `CYCLE_CLKS`-th clock edge after reset, namely edges CYCLE_CLKS, 2*CYCLE_CLKS, and so on. A pin change takes effect only after the next sample edge, and a low pulse that falls between two samples is never seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_n | input | 2 | External interrupt pins, active low |
| tmr_ovf | input | 2 | Timer 0 / timer 1 overflow requests, held until handled |
| ser_req | input | 1 | Serial-port request, held until handled |
| glb_en | input | 1 | Global interrupt enable |
| src_en | input | 5 | Per-source enables |
| src_hi | input | 5 | Per-source high-priority select |
| ext_edge | input | 2 | Per-pin trigger select: 1 falling edge, 0 low level |
| ack | input | 1 | One-cycle acknowledge of the presented vector |
| reti | input | 1 | One-cycle return-from-interrupt strobe |
| irq | output | 1 | Request to the sequencer |
| irq_hi | output | 1 | Presented request is high level |
| vec | output | 8 | Vector address of the presented request |
| in_svc | output | 2 | In-service flags: bit1 high level, bit0 low level |

## Verification
The assertions assume the following about the sequencer:
- `ack` lasts a single cycle.
- `reti` is sent only while some level is in service.
- `ack` and `reti` never come together.

They also assume the timer and serial requests are held until the sequencer handles them. The stimulus keeps to these rules. It drives every input on the falling clock edge. It pulses `ack` only while `irq` is seen high, except for the one deliberate idle acknowledge. It issues `reti` only after a matching acknowledge. External-pin tests are aligned to the bench's own count of sample edges, so every pin change lands at a known distance from a sample.

// File: rtl/intc2l.sv
module intc2l #(
  parameter int CYCLE_CLKS = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ext_n,
  input  logic [1:0] tmr_ovf,
  input  logic       ser_req,
  input  logic       glb_en,
  input  logic [4:0] src_en,
  input  logic [4:0] src_hi,
  input  logic [1:0] ext_edge,
  input  logic       ack,
  input  logic       reti,
  output logic       irq,
  output logic       irq_hi,
  output logic [7:0] vec,
  output logic [1:0] in_svc
);
  localparam int CW = $clog2(CYCLE_CLKS);

  logic [CW-1:0] cnt;
  logic [1:0]    smp, eflag, ext_req;
  logic [4:0]    req, elig, hi_c, lo_c, pick;
  logic [2:0]    idx;
  logic          tick, take;

  assign tick = (cnt == CW'(CYCLE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      smp   <= 2'b11;
      eflag <= 2'b00;
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (tick && ext_edge[i] && smp[i] && !ext_n[i])
          eflag[i] <= 1'b1;
        else if (!ext_edge[i] || (take && idx == 3'(2 * i)))
          eflag[i] <= 1'b0;
        if (tick) smp[i] <= ext_n[i];
      end
    end

  assign ext_req[0] = ext_edge[0] ? eflag[0] : ~smp[0];
  assign ext_req[1] = ext_edge[1] ? eflag[1] : ~smp[1];

  assign req  = {ser_req, tmr_ovf[1], ext_req[1], tmr_ovf[0], ext_req[0]};
  assign elig = req & src_en & {5{glb_en}};
  assign hi_c = elig & src_hi & {5{~in_svc[1]}};
  assign lo_c = elig & ~src_hi & {5{~in_svc[1] & ~in_svc[0]}};
  assign pick = (|hi_c) ? hi_c : lo_c;

  always_comb begin
    idx = 3'd0;
    for (int i = 4; i >= 0; i--)
      if (pick[i]) idx = 3'(i);
  end

  assign irq    = |pick;
  assign irq_hi = |hi_c;
  assign vec    = irq ? 8'h03 + {2'b00, idx, 3'b000} : 8'h00;
  assign take   = ack & irq;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         in_svc <= 2'b00;
    else if (take)      in_svc[irq_hi] <= 1'b1;
    else if (reti) begin
      if (in_svc[1])    in_svc[1] <= 1'b0;
      else              in_svc[0] <= 1'b0;
    end

  p_idle_vec_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> vec == 8'h00);
  p_vec_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (vec[2:0] == 3'd3 && vec <= 8'h23));
  p_global_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glb_en);
  p_no_nest_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_svc[1] |-> !irq);
  p_take_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && irq_hi) |=> in_svc[1]);
  p_take_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq && !irq_hi) |=> in_svc[0]);
  p_reti_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !ack && in_svc[1]) |=> (!in_svc[1] && in_svc[0] == $past(in_svc[0])));
  p_edge_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(eflag[0]) || $rose(eflag[1])) |-> $past(tick));
endmodule

// File: tb/intc2l_test.sv
`timescale 1ns/1ps
module intc2l_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] ext_n = 2'b11, tmr_ovf = 2'b00, ext_edge = 2'b00;
  logic       ser_req = 1'b0, glb_en = 1'b0, ack = 1'b0, reti = 1'b0;
  logic [4:0] src_en = 5'b0, src_hi = 5'b0;
  logic       irq, irq_hi;
  logic [7:0] vec;
  logic [1:0] in_svc;

  int total = 0, fails = 0, ncyc = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  intc2l uut (.clk(clk), .rst_n(rst_n), .ext_n(ext_n), .tmr_ovf(tmr_ovf),
    .ser_req(ser_req), .glb_en(glb_en), .src_en(src_en), .src_hi(src_hi),
    .ext_edge(ext_edge), .ack(ack), .reti(reti), .irq(irq), .irq_hi(irq_hi),
    .vec(vec), .in_svc(in_svc));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic after_tick();
    @(negedge clk);
    while (ncyc % 12 != 0) @(negedge clk);
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    #1;
  endtask

  task automatic pulse_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
    #1;
  endtask

  // {glb, en[4:0], hi[4:0], req{ser,tmr1,tmr0}, irq, irq_hi, vec}
  localparam int NV = 12;
  localparam logic [23:0] TBL [NV] = '{
    {1'b1, 5'b11111, 5'b00000, 3'b001, 1'b1, 1'b0, 8'h0B},  // R2
    {1'b1, 5'b11111, 5'b00000, 3'b010, 1'b1, 1'b0, 8'h1B},  // R2
    {1'b1, 5'b11111, 5'b00000, 3'b100, 1'b1, 1'b0, 8'h23},  // R2
    {1'b1, 5'b11111, 5'b00000, 3'b111, 1'b1, 1'b0, 8'h0B},  // R4
    {1'b1, 5'b11111, 5'b00000, 3'b110, 1'b1, 1'b0, 8'h1B},  // R4
    {1'b1, 5'b11111, 5'b10000, 3'b111, 1'b1, 1'b1, 8'h23},  // R5
    {1'b1, 5'b11111, 5'b01000, 3'b011, 1'b1, 1'b1, 8'h1B},  // R5
    {1'b0, 5'b11111, 5'b00000, 3'b111, 1'b0, 1'b0, 8'h00},  // R3
    {1'b1, 5'b11101, 5'b00000, 3'b001, 1'b0, 1'b0, 8'h00},  // R3
    {1'b1, 5'b11101, 5'b00000, 3'b011, 1'b1, 1'b0, 8'h1B},  // R3 R4
    {1'b1, 5'b11111, 5'b00000, 3'b000, 1'b0, 1'b0, 8'h00},  // R1
    {1'b1, 5'b11111, 5'b11111, 3'b111, 1'b1, 1'b1, 8'h0B}   // R4 R5
  };

  initial begin
    #(20 * 200000);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(3);
    chk("R1 irq", irq, 0); chk("R1 in_svc", in_svc, 0); chk("R1 vec", vec, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc(1);
    chk("R1 irq after release", irq, 0);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      glb_en = TBL[k][23]; src_en = TBL[k][22:18]; src_hi = TBL[k][17:13];
      ser_req = TBL[k][12]; tmr_ovf = TBL[k][11:10];
      #1;
      chk($sformatf("R2/R3/R4/R5 row %0d irq", k), irq, TBL[k][9]);
      chk($sformatf("R5 row %0d irq_hi", k), irq_hi, TBL[k][8]);
      chk($sformatf("R2 row %0d vec", k), vec, TBL[k][7:0]);
    end

    @(negedge clk); glb_en = 1; src_en = 5'b11111; src_hi = 0; tmr_ovf = 0; ser_req = 0;
    pulse_ack();
    chk("R7 idle ack ignored", in_svc, 2'b00);

    @(negedge clk); tmr_ovf = 2'b01; src_hi = 5'b01000;
    pulse_ack();
    chk("R7 low ack", in_svc, 2'b01);
    chk("R6 low blocked", irq, 0);
    @(negedge clk); tmr_ovf = 2'b11; #1;
    chk("R6 preempt irq", irq, 1); chk("R6 preempt vec", vec, 8'h1B);
    chk("R6 preempt hi", irq_hi, 1);
    pulse_ack();
    chk("R7 high ack", in_svc, 2'b11);
    chk("R6 high blocks all", irq, 0);
    @(negedge clk); tmr_ovf = 2'b01;
    pulse_reti();
    chk("R8 reti high first", in_svc, 2'b01);
    @(negedge clk); tmr_ovf = 2'b00;
    pulse_reti();
    chk("R8 reti low", in_svc, 2'b00);

    src_hi = 0;
    after_tick(); ext_n[0] = 1'b0;
    cyc(11);
    chk("R11 before sample", irq, 0);
    cyc(1);
    chk("R9 level irq", irq, 1); chk("R9 level vec", vec, 8'h03);
    ext_n[0] = 1'b1;
    cyc(12);
    chk("R9 level released", irq, 0);

    begin
      int seen = 0;
      after_tick(); cyc(2); ext_n[0] = 1'b0;
      for (int i = 0; i < 6; i++) begin cyc(1); if (irq) seen++; end
      ext_n[0] = 1'b1;
      for (int i = 0; i < 14; i++) begin cyc(1); if (irq) seen++; end
      chk("R11 glitch unseen", seen, 0);
    end

    ext_edge = 2'b10;
    after_tick(); ext_n[1] = 1'b0;
    cyc(12);
    chk("R10 edge irq", irq, 1); chk("R10 edge vec", vec, 8'h13);
    ext_n[1] = 1'b1;
    cyc(24);
    chk("R10 edge persists", irq, 1);
    pulse_ack();
    chk("R10 ack low level", in_svc, 2'b01);
    pulse_reti();
    chk("R8 reti clears", in_svc, 2'b00);
    chk("R10 flag cleared", irq, 0);
    chk("R1 idle vec", vec, 8'h00);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule